// File: doc/BRIEF.md
# Delayed completion interrupt timer

This block sits in the command unit of a network controller and decides when the "unit not active" interrupt is raised. When the command unit moves into its suspend or idle state, the block loads a delay count from the header of the command that has just completed and starts a timer. Each unit of the count is one prescaler period of 256 clocks. When the count runs out, the not-active status bit is set. The delay rolls: entering idle again restarts the timer, and a host resume or start command cancels it. As a result, only the last command of a chain produces the interrupt.

A receive-frame interrupt ends any pending delay early. The receive status bit and the not-active bit are set on the same clock edge, because transmit cleanup can be done while the receive interrupt is serviced. A command whose interrupt bit is set raises a separate completion status bit at once, and the timer has no effect on it. The host clears status bits by writing ones. The request line is high while any status bit is set.

Top module: `cu_idle_irq_timer`

## Requirements
- R1: After reset all three status bits (stat[0] completion, stat[1] not active, stat[2] receive frame) are 0, irq is 0 and no delay is pending.
- R2: A cmd_done strobe with hdr_ibit=1 sets stat[0] on that clock edge, whatever the delay field holds. With hdr_ibit=0 it sets no status bit.
- R3: A cu_enter_idle strobe with hdr_dly=0 sets stat[1] on that clock edge.
- R4: A cu_enter_idle strobe with hdr_dly=D>0 sets stat[1] exactly D*256 clock edges after the arming edge, and never earlier.
- R5: A cmd_done strobe alone never arms the timer. With no cu_enter_idle, stat[1] stays 0 whatever hdr_dly holds.
- R6: rx_irq sets stat[2]. If a delay is pending, rx_irq cancels it and sets stat[1] on the same edge as stat[2].
- R7: host_resume cancels a pending delay, and stat[1] is then not set by that delay.
- R8: A cu_enter_idle while a delay is pending restarts the timer from the new field value.
- R9: ack_we with ack_mask bit i=1 clears stat[i]. A set on the same edge wins over the clear.
- R10: irq is 1 exactly when at least one status bit is 1.
- R11: When cmd_done with hdr_ibit=1 and cu_enter_idle with nonzero hdr_dly arrive on the same edge, stat[0] and stat[1] do not rise on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_dly | input | 5 | Delay field of the command just completed |
| hdr_ibit | input | 1 | Interrupt bit of the command just completed |
| cmd_done | input | 1 | Strobe: a command completed |
| cu_enter_idle | input | 1 | Strobe: command unit entered suspend or idle |
| host_resume | input | 1 | Strobe: host issued resume or start |
| rx_irq | input | 1 | Strobe: receive-frame interrupt |
| ack_we | input | 1 | Host acknowledge write |
| ack_mask | input | 3 | Write-1-to-clear mask for the status bits |
| stat | output | 3 | Status bits: [0] completion, [1] not active, [2] receive frame |
| irq | output | 1 | Interrupt request, OR of the status bits |

## Verification
A pending flag that is set by mistake shows up only when a receive strobe arrives: the not-active bit then appears with the receive bit, where it should have stayed clear. A prescaler or count that is off by one shifts the rise of the not-active bit by one edge or by 256 edges. For this reason the bench measures the latency edge by edge against D*256. A cancellation that fails to take effect appears at the ports only after the full programmed delay, so the bench waits longer than that delay before it concludes that no interrupt followed.

// File: rtl/cu_idle_irq_timer.sv
module cu_idle_irq_timer #(
  parameter int DLY_W    = 5,
  parameter int PRESCALE = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] hdr_dly,
  input  logic             hdr_ibit,
  input  logic             cmd_done,
  input  logic             cu_enter_idle,
  input  logic             host_resume,
  input  logic             rx_irq,
  input  logic             ack_we,
  input  logic [2:0]       ack_mask,
  output logic [2:0]       stat,
  output logic             irq
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             pend;
  logic [DLY_W-1:0] cnt;
  logic [PRE_W-1:0] pre;

  wire tick     = pend && (pre == PRE_W'(PRESCALE - 1));
  wire expire   = tick && (cnt == DLY_W'(1));
  wire rx_hit   = rx_irq && pend;
  wire zero_ent = cu_enter_idle && (hdr_dly == '0);
  wire arm      = cu_enter_idle && (hdr_dly != '0);

  wire [2:0] set_v = {rx_irq, expire | rx_hit | zero_ent, cmd_done & hdr_ibit};
  wire [2:0] clr_v = ack_we ? ack_mask : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      pend <= 1'b0;
      cnt  <= '0;
      pre  <= '0;
    end else begin
      stat <= (stat & ~clr_v) | set_v;
      if (arm) begin
        pend <= 1'b1;
        cnt  <= hdr_dly;
        pre  <= '0;
      end else if (host_resume || rx_hit || expire || zero_ent) begin
        pend <= 1'b0;
      end else if (pend) begin
        pre <= tick ? '0 : PRE_W'(pre + 1'b1);
        if (tick) cnt <= cnt - 1'b1;
      end
    end
  end

  assign irq = |stat;

  logic [31:0]      chk_el;
  logic [DLY_W-1:0] chk_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_el <= '0;
      chk_d  <= '0;
    end else if (arm) begin
      chk_el <= '0;
      chk_d  <= hdr_dly;
    end else begin
      chk_el <= chk_el + 1;
    end
  end

  p_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (chk_el == 32'(chk_d) * PRESCALE - 1));

  p_cx_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && hdr_ibit) |=> stat[0]);

  p_zero_dly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_enter_idle && hdr_dly == '0) |=> stat[1]);

  p_rx_collapse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && pend) |=> (stat[1] && stat[2]));

  p_resume_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_resume && !cu_enter_idle) |=> !pend);

  p_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[1]) |-> $past(ack_we && ack_mask[1]));

  p_not_together_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && hdr_ibit && cu_enter_idle && hdr_dly != '0 && !rx_irq) |=> !$rose(stat[1]));
endmodule

// File: tb/sim_cu_idle_irq_timer.sv
module sim_cu_idle_irq_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] hdr_dly = '0;
  logic       hdr_ibit = 1'b0, cmd_done = 1'b0, cu_enter_idle = 1'b0;
  logic       host_resume = 1'b0, rx_irq = 1'b0, ack_we = 1'b0;
  logic [2:0] ack_mask = '0;
  logic [2:0] stat;
  logic       irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cu_idle_irq_timer u0 (.clk(clk), .rst_n(rst_n), .hdr_dly(hdr_dly), .hdr_ibit(hdr_ibit),
    .cmd_done(cmd_done), .cu_enter_idle(cu_enter_idle), .host_resume(host_resume),
    .rx_irq(rx_irq), .ack_we(ack_we), .ack_mask(ack_mask), .stat(stat), .irq(irq));

  localparam int NV = 6;
  localparam int VD [NV] = '{0, 1, 2, 3, 7, 5};
  localparam int VI [NV] = '{0, 1, 0, 1, 0, 1};
  localparam int VL [NV] = '{0, 256, 512, 768, 1792, 1280};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic release_all();
    @(negedge clk);
    cmd_done = 0; hdr_ibit = 0; cu_enter_idle = 0; host_resume = 0;
    rx_irq = 0; ack_we = 0; ack_mask = 0; hdr_dly = 0;
  endtask

  task automatic ack_all();
    @(negedge clk); ack_we = 1; ack_mask = 3'b111;
    release_all();
  endtask

  task automatic enter(input int d);
    @(negedge clk); cu_enter_idle = 1; hdr_dly = 5'(d);
    release_all();
  endtask

  function automatic int wait_cna_dummy();
    return 0;
  endfunction

  int lat;
  task automatic measure(input int lim);
    lat = 0;
    while (!stat[1] && lat < lim) begin
      @(negedge clk); lat++;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_cyc(3);
    @(negedge clk);
    chk(stat == 3'b000, "R1 stat", stat, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rst_n = 1;
    idle_cyc(300);
    chk(stat == 3'b000, "R1 no pending", stat, 0);

    for (int v = 0; v < NV; v++) begin
      ack_all();
      @(negedge clk);
      cmd_done = 1; hdr_ibit = VI[v][0]; cu_enter_idle = 1; hdr_dly = 5'(VD[v]);
      release_all();
      chk(stat[0] == VI[v][0], "R2 cx", stat[0], VI[v]);
      if (VD[v] != 0) chk(stat[1] == 1'b0, "R11 not together", stat[1], 0);
      measure(9000);
      chk(lat == VL[v], (VD[v] == 0) ? "R3 zero delay" : "R4 latency", lat, VL[v]);
      chk(irq == 1'b1, "R10 irq set", irq, 1);
    end

    ack_all();
    @(negedge clk);
    chk(stat == 3'b000 && irq == 1'b0, "R9 clear all", stat, 0);

    @(negedge clk); cmd_done = 1; hdr_ibit = 0; hdr_dly = 5'd3;
    release_all();
    chk(stat == 3'b000, "R2 no ibit", stat, 0);
    idle_cyc(1000);
    chk(stat[1] == 1'b0, "R5 no arm", stat[1], 0);

    enter(4);
    idle_cyc(300);
    @(negedge clk); rx_irq = 1;
    release_all();
    chk(stat[2] == 1'b1, "R6 fr", stat[2], 1);
    chk(stat[1] == 1'b1, "R6 collapse", stat[1], 1);
    ack_all();
    idle_cyc(1100);
    chk(stat == 3'b000, "R6 cancelled", stat, 0);

    @(negedge clk); rx_irq = 1;
    release_all();
    chk(stat == 3'b100, "R6 rx no pending", stat, 4);
    chk(irq == 1'b1, "R10 irq fr only", irq, 1);
    ack_all();

    enter(2);
    idle_cyc(100);
    @(negedge clk); host_resume = 1;
    release_all();
    idle_cyc(700);
    chk(stat[1] == 1'b0, "R7 resume cancel", stat[1], 0);

    enter(3);
    idle_cyc(199);
    enter(1);
    measure(2000);
    chk(lat == 256, "R8 rearm", lat, 256);
    ack_all();
    idle_cyc(900);
    chk(stat[1] == 1'b0, "R8 old timer gone", stat[1], 0);

    @(negedge clk); cu_enter_idle = 1; hdr_dly = 0; ack_we = 1; ack_mask = 3'b111;
    release_all();
    chk(stat == 3'b010, "R9 set wins", stat, 2);
    @(negedge clk); ack_we = 1; ack_mask = 3'b001;
    release_all();
    chk(stat == 3'b010, "R9 mask select", stat, 2);
    ack_all();
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq clear", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule